// File: doc/BRIEF.md
# Time-Slot Serial Receive Channel

This block is the receive half of a time-division multiplexed serial port. It takes a bit clock, a data line and a frame-start marker from the port's pins. These three inputs are registered in the system clock domain. The receive data is sampled on the bit-clock edge that the configuration selects. Bits go into a 32-bit shift register. When a word of the configured length is complete in a slot that the slot mask allows, the word is moved into a 24-bit holding register. On that move, the configured word length, alignment and bit order are applied.

The host takes words through a valid/ready output. `word_valid` is the full flag. A word is consumed in a cycle where `word_valid` and `word_ready` are both high. The holding register is one deep, and the serial line cannot be stalled. So back-pressure is not passed upstream. If the host is still holding off when the next enabled word completes, the new word is dropped and the overrun flag is set. The host may hold `word_ready` high at any time; it has no effect while `word_valid` is low.

The block produces three requests: a word request, an exception request for overrun, and a network-mode pulse when the final slot of a frame ends. Once the final slot of a frame has ended, the receiver ignores the data line until the next frame-start marker.

Top module: `tdm_rx_channel`

## Requirements
- R1: When an enabled slot completes a word, the word appears on `word_data` and `word_valid` is set. A cycle with `word_valid` and `word_ready` both high clears `word_valid`. After reset, `word_valid`, `overrun`, all requests and `word_data` are zero.
- R2: An enabled word that completes while `word_valid` is still set, and is not consumed in that same cycle, sets `overrun`. In that case `word_data` keeps the older word and the new word is discarded.
- R3: `cfg_wl` selects the word length: 0 = 8 bits, 1 = 12, 2 = 16, 3 = 24, 4 = 32 keeping the first 24 received bits, 5 = 32 keeping the last 24 received bits. Bits of `word_data` outside the word read as zero.
- R4: For 8-, 12- and 16-bit words, `cfg_align15` = 0 places the word's MSB at bit 23 and `cfg_align15` = 1 places it at bit 15.
- R5: `cfg_lsb_first` = 0 treats the first received bit of a word as its MSB. `cfg_lsb_first` = 1 treats it as its LSB.
- R6: In the 32-bit formats, the 24 kept bits fill `word_data[23:0]` with their significance preserved.
- R7: Bit n of `cfg_slot_mask` enables slot n. A word completed in a disabled slot changes neither `word_valid`, `word_data` nor `overrun`.
- R8: `irq_exc` is high exactly when `overrun`, `word_valid` and `cfg_exc_en` are all high. `overrun` is cleared only by a consuming read that follows a `stat_rd` pulse seen while `overrun` was set. A read alone does not clear it, and a status pulse alone does not clear it.
- R9: `irq_word` is high exactly when `word_valid` and `cfg_irq_en` are high.
- R10: With `cfg_network` = 1 and `cfg_last_en` = 1, `irq_last` pulses for one cycle when slot `cfg_slots_m1` of a frame ends, whether that slot is masked or not. In normal mode (`cfg_network` = 0) the frame is one slot long and `irq_last` stays low.
- R11: `cfg_rise_edge` = 0 samples data and frame start on the falling bit-clock edge. `cfg_rise_edge` = 1 samples them on the rising edge.
- R12: If a word completes in the same cycle as a consuming read, the read takes the older word. The new word is then loaded, `word_valid` stays set and no overrun is flagged.
- R13: A sampled `fsync_i` = 1 starts slot 0 with that bit as the first bit of its word, abandoning any partial word. After the final slot, sampled bits are ignored until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial bit clock from the pin |
| sdata_i | input | 1 | Serial receive data |
| fsync_i | input | 1 | Frame start, high with the first bit of slot 0 |
| cfg_wl | input | 3 | Word length / format code |
| cfg_align15 | input | 1 | Short words aligned to bit 15 instead of 23 |
| cfg_lsb_first | input | 1 | Bit order of incoming words |
| cfg_rise_edge | input | 1 | Sampling bit-clock edge select |
| cfg_network | input | 1 | Multi-slot frame mode |
| cfg_slots_m1 | input | SLOT_W | Slots per frame minus one (network mode) |
| cfg_slot_mask | input | MAX_SLOTS | Per-slot receive enable |
| cfg_irq_en | input | 1 | Word request enable |
| cfg_exc_en | input | 1 | Exception request enable |
| cfg_last_en | input | 1 | Last-slot request enable |
| word_valid | output | 1 | Holding register full |
| word_ready | input | 1 | Host accepts the held word |
| word_data | output | 24 | Held word |
| stat_rd | input | 1 | Host status-read strobe |
| overrun | output | 1 | Overrun flag |
| irq_word | output | 1 | Word request |
| irq_exc | output | 1 | Exception request |
| irq_last | output | 1 | Last-slot pulse |

## Verification
Two events can fall on one clock edge: a word finishing on the serial side, and a host read consuming the held word. The bench provokes this by raising `word_ready` exactly on the cycle in which the last bit's sampling edge is detected. In that cycle it captures `word_data` to confirm the read got the older word. It then checks that the new word is held, `word_valid` stays set and `overrun` stays clear. The contrasting case is a completion with no read at all, which must raise `overrun` and keep the older word.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;
  localparam int HOLD_W  = 24;
  localparam int SHIFT_W = 32;
  localparam int LEN_W   = 6;

  // Word-length code to bit count; unassigned codes behave as 24 bits.
  function automatic logic [LEN_W-1:0] wl_len(input logic [2:0] code);
    case (code)
      3'd0:        wl_len = LEN_W'(8);
      3'd1:        wl_len = LEN_W'(12);
      3'd2:        wl_len = LEN_W'(16);
      3'd4, 3'd5:  wl_len = LEN_W'(32);
      default:     wl_len = LEN_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/tdmrx_edge.sv
module tdmrx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sd_i,
  input  logic fs_i,
  input  logic rise_sel,
  output logic samp_o,
  output logic bit_o,
  output logic fs_o
);
  logic sclk_q, sclk_qq, sd_q, fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      sd_q    <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      sclk_q  <= sclk_i;
      sclk_qq <= sclk_q;
      sd_q    <= sd_i;
      fs_q    <= fs_i;
    end
  end

  assign samp_o = rise_sel ? (sclk_q & ~sclk_qq) : (~sclk_q & sclk_qq);
  assign bit_o  = sd_q;
  assign fs_o   = fs_q;
endmodule

// File: rtl/tdmrx_slot.sv
module tdmrx_slot #(
  parameter int MAX_SLOTS = 32,
  parameter int LEN_W     = 6,
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_i,
  input  logic              fs_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SLOT_W-1:0] last_idx_i,
  output logic              take_o,
  output logic              first_o,
  output logic              done_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              final_o
);
  logic              active;
  logic [LEN_W-1:0]  pos, pos_n;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    take_o  = samp_i & (fs_i | active);
    first_o = samp_i & (fs_i | (active & (pos == '0)));
    slot_o  = fs_i ? '0 : slot;
    pos_n   = fs_i ? LEN_W'(1) : pos + LEN_W'(1);
    done_o  = take_o & (pos_n == len_i);
    final_o = done_o & (slot_o == last_idx_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
      slot   <= '0;
    end else if (take_o) begin
      if (done_o) begin
        pos    <= '0;
        active <= ~final_o;
        slot   <= final_o ? '0 : slot_o + SLOT_W'(1);
      end else begin
        pos    <= pos_n;
        slot   <= slot_o;
        active <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdmrx_pack.sv
module tdmrx_pack
  import tdmrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              first_i,
  input  logic              bit_i,
  input  logic              lsb_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [2:0]        code_i,
  input  logic              align15_i,
  output logic [HOLD_W-1:0] word_o
);
  logic [SHIFT_W-1:0] sr, sr_next, w;
  logic [LEN_W-1:0]   rsh, lsh;
  logic [HOLD_W-1:0]  base;

  always_comb begin
    if (first_i)
      sr_next = lsb_i ? {bit_i, {(SHIFT_W-1){1'b0}}} : {{(SHIFT_W-1){1'b0}}, bit_i};
    else
      sr_next = lsb_i ? {bit_i, sr[SHIFT_W-1:1]} : {sr[SHIFT_W-2:0], bit_i};
    rsh  = LEN_W'(SHIFT_W) - len_i;
    w    = lsb_i ? (sr_next >> rsh) : sr_next;
    base = w[HOLD_W-1:0];
    lsh  = align15_i ? (LEN_W'(16) - len_i) : (LEN_W'(HOLD_W) - len_i);
    case (code_i)
      3'd0, 3'd1, 3'd2: word_o = base << lsh;
      3'd4:             word_o = lsb_i ? w[HOLD_W-1:0] : w[SHIFT_W-1:SHIFT_W-HOLD_W];
      3'd5:             word_o = lsb_i ? w[SHIFT_W-1:SHIFT_W-HOLD_W] : w[HOLD_W-1:0];
      default:          word_o = base;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= '0;
    else if (take_i) sr <= sr_next;
  end
endmodule

// File: rtl/tdm_rx_channel.sv
module tdm_rx_channel
  import tdmrx_pkg::*;
#(
  parameter int MAX_SLOTS = 32,
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_i,
  input  logic                 sdata_i,
  input  logic                 fsync_i,
  input  logic [2:0]           cfg_wl,
  input  logic                 cfg_align15,
  input  logic                 cfg_lsb_first,
  input  logic                 cfg_rise_edge,
  input  logic                 cfg_network,
  input  logic [SLOT_W-1:0]    cfg_slots_m1,
  input  logic [MAX_SLOTS-1:0] cfg_slot_mask,
  input  logic                 cfg_irq_en,
  input  logic                 cfg_exc_en,
  input  logic                 cfg_last_en,
  output logic                 word_valid,
  input  logic                 word_ready,
  output logic [HOLD_W-1:0]    word_data,
  input  logic                 stat_rd,
  output logic                 overrun,
  output logic                 irq_word,
  output logic                 irq_exc,
  output logic                 irq_last
);
  logic              samp, sbit, sfs;
  logic              take, first, done, fin;
  logic [SLOT_W-1:0] slot, last_idx;
  logic [LEN_W-1:0]  len;
  logic [HOLD_W-1:0] packed_word, hold;
  logic              full, ovr, armed, capture, rd_fire, ovr_evt;

  assign len      = wl_len(cfg_wl);
  assign last_idx = cfg_network ? cfg_slots_m1 : '0;

  tdmrx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sd_i(sdata_i), .fs_i(fsync_i),
    .rise_sel(cfg_rise_edge), .samp_o(samp), .bit_o(sbit), .fs_o(sfs)
  );

  tdmrx_slot #(.MAX_SLOTS(MAX_SLOTS), .LEN_W(LEN_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .samp_i(samp), .fs_i(sfs), .len_i(len),
    .last_idx_i(last_idx), .take_o(take), .first_o(first), .done_o(done),
    .slot_o(slot), .final_o(fin)
  );

  tdmrx_pack u_pack (
    .clk(clk), .rst_n(rst_n), .take_i(take), .first_i(first), .bit_i(sbit),
    .lsb_i(cfg_lsb_first), .len_i(len), .code_i(cfg_wl), .align15_i(cfg_align15),
    .word_o(packed_word)
  );

  assign capture = done & cfg_slot_mask[slot];
  assign rd_fire = word_ready & full;
  assign ovr_evt = capture & full & ~rd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= '0;
      full     <= 1'b0;
      ovr      <= 1'b0;
      armed    <= 1'b0;
      irq_last <= 1'b0;
    end else begin
      if (capture && !ovr_evt) hold <= packed_word;
      if (capture)      full <= 1'b1;
      else if (rd_fire) full <= 1'b0;
      if (ovr_evt) ovr <= 1'b1;
      else if (rd_fire && armed) ovr <= 1'b0;
      if (rd_fire && armed) armed <= 1'b0;
      else if (stat_rd && ovr) armed <= 1'b1;
      irq_last <= fin & cfg_network & cfg_last_en;
    end
  end

  assign word_valid = full;
  assign word_data  = hold;
  assign overrun    = ovr;
  assign irq_word   = full & cfg_irq_en;
  assign irq_exc    = ovr & full & cfg_exc_en;

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !capture) |=> !word_valid); // R1
  AST_OVR_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($stable(word_data) && word_valid && $past(word_valid))); // R2
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_slot_mask[slot] && !full) |=> !word_valid); // R7
  AST_OVR_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $past(rd_fire)); // R8
  AST_LAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_last |=> !irq_last); // R10
endmodule

// File: tb/tdm_rx_channel_bench.sv
module tdm_rx_channel_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, sd = 1'b0, fs = 1'b0;
  logic [2:0] wl = 3'd0;
  logic al = 1'b0, lsb = 1'b0, rise = 1'b0, net = 1'b0;
  logic [4:0] slots_m1 = 5'd0;
  logic [31:0] mask = 32'hFFFF_FFFF;
  logic irq_en = 1'b0, exc_en = 1'b0, last_en = 1'b1;
  logic ready = 1'b0, srd = 1'b0;
  logic valid, ovr, irqw, irqx, irql;
  logic [23:0] data;

  int errors = 0, checks = 0, lastcnt = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [23:0] coll_data;
  logic done_flag = 1'b0;

  always #10 clk = ~clk;

  tdm_rx_channel u_tdm_rx_channel (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sd), .fsync_i(fs),
    .cfg_wl(wl), .cfg_align15(al), .cfg_lsb_first(lsb), .cfg_rise_edge(rise),
    .cfg_network(net), .cfg_slots_m1(slots_m1), .cfg_slot_mask(mask),
    .cfg_irq_en(irq_en), .cfg_exc_en(exc_en), .cfg_last_en(last_en),
    .word_valid(valid), .word_ready(ready), .word_data(data), .stat_rd(srd),
    .overrun(ovr), .irq_word(irqw), .irq_exc(irqx), .irq_last(irql)
  );

  always @(negedge clk) if (rst_n && irql) lastcnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bits_of(input int code);
    case (code)
      0: return 8; 1: return 12; 2: return 16; 3: return 24; default: return 32;
    endcase
  endfunction

  function automatic logic [23:0] exp_word(input int code, input logic a, input logic l, input logic [31:0] v);
    int k = bits_of(code);
    logic [31:0] sh;
    case (code)
      0, 1, 2: begin sh = a ? (v << (16 - k)) : (v << (24 - k)); return sh[23:0]; end
      3:       return v[23:0];
      4:       return l ? v[23:0] : v[31:8];
      default: return l ? v[31:8] : v[23:0];
    endcase
  endfunction

  function automatic logic [31:0] rnd_val(input int k);
    seed = seed * 32'd1103515245 + 32'd12345;
    return (k == 32) ? (seed ^ {seed[15:0], seed[31:16]}) : ((seed ^ (seed >> 7)) & ((32'h1 << k) - 1));
  endfunction

  task automatic drive_bit(input logic b, input logic f, input logic collide);
    @(negedge clk); sd = b; fs = f;
    @(negedge clk); sclk = rise;
    if (collide) begin
      @(negedge clk); coll_data = data; ready = 1'b1;
      @(negedge clk); ready = 1'b0;
    end else begin
      repeat (2) @(negedge clk);
    end
    sclk = ~rise;
    @(negedge clk); fs = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] v, input int k, input logic f, input logic collide);
    for (int i = 0; i < k; i++)
      drive_bit(lsb ? v[i] : v[k-1-i], f && (i == 0), collide && (i == k - 1));
  endtask

  task automatic read_word;
    @(negedge clk); ready = 1'b1;
    @(negedge clk); ready = 1'b0;
  endtask

  task automatic status_read;
    @(negedge clk); srd = 1'b1;
    @(negedge clk); srd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v0, v1, v2, v3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset valid", valid, 0);
    check("R1 reset overrun", ovr, 0);
    check("R1 reset data", data, 0);
    check("R1 reset requests", {irqw, irqx, irql}, 0);

    // Sweep: R3 R4 R5 R6 R11 over every format, alignment, order and edge
    for (int code = 0; code < 6; code++)
      for (int a = 0; a < 2; a++)
        for (int l = 0; l < 2; l++)
          for (int p = 0; p < 2; p++) begin
            @(negedge clk);
            wl = 3'(code); al = a[0]; lsb = l[0]; rise = p[0];
            @(negedge clk); sclk = ~rise;
            repeat (3) @(negedge clk);
            v = rnd_val(bits_of(code));
            send_word(v, bits_of(code), 1'b1, 1'b0);
            check("R1 valid after word", valid, 1);
            check("R3 R4 R5 R6 R11 word", data, exp_word(code, a[0], l[0], v));
            read_word();
            check("R1 read clears valid", valid, 0);
          end
    check("R10 no last pulse in normal mode", lastcnt, 0);

    // R13 restart mid-word, idle after final slot
    @(negedge clk); wl = 3'd3; al = 0; lsb = 0; rise = 0;
    @(negedge clk); sclk = 1'b1; repeat (3) @(negedge clk);
    send_word(32'hF, 4, 1'b1, 1'b0);
    v = rnd_val(24);
    send_word(v, 24, 1'b1, 1'b0);
    check("R13 restart takes new word", data, v[23:0]);
    read_word();
    send_word(rnd_val(24), 24, 1'b0, 1'b0);
    check("R13 ignored without frame start", valid, 0);

    // R9 word request, R2 R8 overrun and two-step clear
    irq_en = 1; exc_en = 1;
    v0 = rnd_val(24); v1 = rnd_val(24); v2 = rnd_val(24);
    send_word(v0, 24, 1'b1, 1'b0);
    check("R9 word request", irqw, 1);
    check("R8 no exception yet", irqx, 0);
    irq_en = 0;
    @(negedge clk);
    check("R9 request gated by enable", irqw, 0);
    send_word(v1, 24, 1'b1, 1'b0);
    check("R2 overrun set", ovr, 1);
    check("R2 old word kept", data, v0[23:0]);
    check("R8 exception request", irqx, 1);
    read_word();
    check("R8 read alone keeps overrun", ovr, 1);
    check("R8 exception drops with valid", irqx, 0);
    send_word(v2, 24, 1'b1, 1'b0);
    check("R2 word after read accepted", data, v2[23:0]);
    check("R8 exception again", irqx, 1);
    status_read();
    check("R8 status alone keeps overrun", ovr, 1);
    read_word();
    check("R8 status then read clears", ovr, 0);
    check("R8 exception cleared", irqx, 0);
    exc_en = 0;

    // R12 completion and read on the same edge
    v0 = rnd_val(24); v1 = rnd_val(24);
    send_word(v0, 24, 1'b1, 1'b0);
    send_word(v1, 24, 1'b1, 1'b1);
    check("R12 read got older word", coll_data, v0[23:0]);
    check("R12 new word held", data, v1[23:0]);
    check("R12 valid stays", valid, 1);
    check("R12 no overrun", ovr, 0);
    read_word();

    // R7 slot mask, R10 last-slot pulse, network mode with 4 slots
    @(negedge clk); net = 1; slots_m1 = 5'd3; mask = 32'h0000_0005; wl = 3'd0;
    v0 = rnd_val(8); v1 = rnd_val(8); v2 = rnd_val(8); v3 = rnd_val(8);
    send_word(v0, 8, 1'b1, 1'b0);
    check("R7 slot0 enabled", data, {v0[7:0], 16'h0});
    send_word(v1, 8, 1'b0, 1'b0);
    check("R7 masked slot keeps word", data, {v0[7:0], 16'h0});
    check("R7 masked slot no overrun", ovr, 0);
    send_word(v2, 8, 1'b0, 1'b0);
    check("R2 overrun in enabled slot", ovr, 1);
    status_read();
    read_word();
    check("R8 overrun cleared", ovr, 0);
    check("R10 no pulse before last slot", lastcnt, 0);
    send_word(v3, 8, 1'b0, 1'b0);
    check("R7 masked last slot stays empty", valid, 0);
    check("R10 one last-slot pulse", lastcnt, 1);
    send_word(rnd_val(8), 8, 1'b0, 1'b0);
    check("R13 idle after final slot", valid, 0);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule